// File: doc/BRIEF.md
# Dual-Channel Sequential Delay Memory

This block holds two separate nibble-wide memories. Each memory is reached only through a write pointer and a read pointer that live inside the block. Each channel has its own clock, and the two channels share nothing except the asynchronous power-on reset. A write stores the input nibble at the write pointer and then advances the pointer. A read presents the word at the read pointer on the output, one clock edge later, and then advances that pointer. Each pointer can be cleared to zero from outside.

The block has no full or empty tracking. Both pointers run freely and wrap at the end of the array. The distance between a write clear and a later read clear therefore sets a fixed delay. With continuous writes and reads, the output repeats the input stream that many edges later, which is how the block serves as a variable-length line or field delay. While reading is disabled, the output-enable flag is low and the output bus reads zero. This models a bus that would be released to high impedance.

Top module: `dual_delay_mem`

## Requirements
- R1: The two channels are independent. Writes, reads and clears on one channel never change the stored words, pointers or outputs of the other channel.
- R2: When the active-low write enable is 0 at a rising edge, the input nibble is stored at the write pointer and the write pointer advances by one.
- R3: When the write enable is 1 at a rising edge, nothing is stored and the write pointer keeps its value.
- R4: When the active-low write clear is 0 at a rising edge, the write pointer becomes 0. If the write enable is also 0 at that edge, the nibble is stored at address 0 and the pointer then holds 1.
- R5: When the active-low read enable is 0 at a rising edge, the output after that edge carries the word at the read pointer, the output enable is 1, and the read pointer advances by one.
- R6: When the read enable is 1 at a rising edge, the output enable is 0 and the output is 0 after that edge, and the read pointer keeps its value.
- R7: When the active-low read clear is 0 at a rising edge, the read pointer becomes 0. If the read enable is also 0 at that edge, address 0 is read and the pointer then holds 1.
- R8: Both pointers wrap from DEPTH-1 to 0 without any flag or stall. A write past the last location overwrites address 0.
- R9: When a read and a write hit the same address at the same edge, the read returns the word stored there before that edge.
- R10: While the active-low power-on reset is 0, all four pointers are 0, both output enables are 0 and both outputs are 0. Release takes effect two edges later in each clock domain.
- R11: With writes and reads both enabled on every edge, a read clear issued N edges after a write clear (0 < N < DEPTH) makes each output word equal to the input written N edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Asynchronous power-on reset, active low |
| a_clk | input | 1 | Channel A clock |
| a_din | input | 4 | Channel A write data |
| a_wen_n | input | 1 | Channel A write enable, active low |
| a_wclr_n | input | 1 | Channel A write pointer clear, active low |
| a_ren_n | input | 1 | Channel A read enable, active low |
| a_rclr_n | input | 1 | Channel A read pointer clear, active low |
| a_dout | output | 4 | Channel A read data, zero while disabled |
| a_dout_oe | output | 1 | Channel A output enable (high = driven) |
| b_clk | input | 1 | Channel B clock |
| b_din | input | 4 | Channel B write data |
| b_wen_n | input | 1 | Channel B write enable, active low |
| b_wclr_n | input | 1 | Channel B write pointer clear, active low |
| b_ren_n | input | 1 | Channel B read enable, active low |
| b_rclr_n | input | 1 | Channel B read pointer clear, active low |
| b_dout | output | 4 | Channel B read data, zero while disabled |
| b_dout_oe | output | 1 | Channel B output enable (high = driven) |

## Verification
The bench builds the block with DEPTH set to 16 rather than a production depth near one million words. This lets a single directed run fill a channel completely, overwrite address 0 through the wrap, and read past the last location back to address 0. The small depth also means a delay of five edges, held over twenty edges, crosses the wrap boundary while write and read both run. Channel B runs on a clock of a different period, so its contents and quiet output are checked across the whole channel A activity.

// File: rtl/ddm_pkg.sv
package ddm_pkg;
  localparam int DATA_W = 4;
  localparam int NUM_CH = 2;
  typedef logic [DATA_W-1:0] nib_t;
endpackage

// File: rtl/ddm_rst_sync.sv
module ddm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/ddm_ptr.sv
module ddm_ptr #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = base;
    if (step) begin
      if (base == LAST) ptr_d = '0;
      else              ptr_d = base + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end
endmodule

// File: rtl/ddm_store.sv
module ddm_store
  import ddm_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_go,
  input  logic [AW-1:0] waddr,
  input  nib_t          wdata,
  input  logic [AW-1:0] raddr,
  output nib_t          rdata
);
  nib_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_go) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ddm_chan.sv
module ddm_chan
  import ddm_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic por_n,
  input  nib_t din,
  input  logic wen_n,
  input  logic wclr_n,
  input  logic ren_n,
  input  logic rclr_n,
  output nib_t dout,
  output logic dout_oe
);
  logic          srst_n;
  logic          wr_go;
  logic          rd_go;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW-1:0] wbase;
  logic [AW-1:0] rbase;
  nib_t          rdata;
  nib_t          dout_d;
  logic          oe_d;

  ddm_rst_sync u_rst (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (srst_n)
  );

  assign wr_go = ~wen_n & srst_n;
  assign rd_go = ~ren_n & srst_n;
  assign wbase = wclr_n ? wptr : '0;
  assign rbase = rclr_n ? rptr : '0;

  ddm_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk   (clk),
    .rst_n (srst_n),
    .step  (wr_go),
    .base  (wbase),
    .ptr   (wptr)
  );

  ddm_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk   (clk),
    .rst_n (srst_n),
    .step  (rd_go),
    .base  (rbase),
    .ptr   (rptr)
  );

  ddm_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .wr_go (wr_go),
    .waddr (wbase),
    .wdata (din),
    .raddr (rbase),
    .rdata (rdata)
  );

  always_comb begin
    oe_d   = rd_go;
    dout_d = rd_go ? rdata : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dout_oe <= 1'b0;
      dout    <= '0;
    end else begin
      dout_oe <= oe_d;
      dout    <= dout_d;
    end
  end
endmodule

// File: rtl/dual_delay_mem.sv
module dual_delay_mem
  import ddm_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       por_n,
  input  logic       a_clk,
  input  logic [3:0] a_din,
  input  logic       a_wen_n,
  input  logic       a_wclr_n,
  input  logic       a_ren_n,
  input  logic       a_rclr_n,
  output logic [3:0] a_dout,
  output logic       a_dout_oe,
  input  logic       b_clk,
  input  logic [3:0] b_din,
  input  logic       b_wen_n,
  input  logic       b_wclr_n,
  input  logic       b_ren_n,
  input  logic       b_rclr_n,
  output logic [3:0] b_dout,
  output logic       b_dout_oe
);
  logic [NUM_CH-1:0] clk_v;
  logic [NUM_CH-1:0] wen_v;
  logic [NUM_CH-1:0] wclr_v;
  logic [NUM_CH-1:0] ren_v;
  logic [NUM_CH-1:0] rclr_v;
  logic [NUM_CH-1:0] oe_v;
  nib_t              din_v  [NUM_CH];
  nib_t              dout_v [NUM_CH];

  assign clk_v  = {b_clk, a_clk};
  assign wen_v  = {b_wen_n, a_wen_n};
  assign wclr_v = {b_wclr_n, a_wclr_n};
  assign ren_v  = {b_ren_n, a_ren_n};
  assign rclr_v = {b_rclr_n, a_rclr_n};
  assign din_v[0] = a_din;
  assign din_v[1] = b_din;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ddm_chan #(.DEPTH(DEPTH)) u_chan (
      .clk     (clk_v[ch]),
      .por_n   (por_n),
      .din     (din_v[ch]),
      .wen_n   (wen_v[ch]),
      .wclr_n  (wclr_v[ch]),
      .ren_n   (ren_v[ch]),
      .rclr_n  (rclr_v[ch]),
      .dout    (dout_v[ch]),
      .dout_oe (oe_v[ch])
    );
  end

  assign a_dout    = dout_v[0];
  assign b_dout    = dout_v[1];
  assign a_dout_oe = oe_v[0];
  assign b_dout_oe = oe_v[1];
endmodule

// File: rtl/ddm_chk.sv
module ddm_chk #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          por_n,
  input logic          srst_n,
  input logic          wen_n,
  input logic          wclr_n,
  input logic          ren_n,
  input logic          rclr_n,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic [3:0]    dout,
  input logic          dout_oe
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assert_wstep_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (wclr_n && !wen_n && wptr != LAST) |=> (wptr == $past(wptr) + AW'(1)));

  assert_whold_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (wclr_n && wen_n) |=> $stable(wptr));

  assert_wclr_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (!wclr_n && wen_n) |=> (wptr == '0));

  assert_wclr_go_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (!wclr_n && !wen_n) |=> (wptr == AW'(1)));

  assert_oe_on_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !ren_n |=> dout_oe);

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!srst_n)
    ren_n |=> !dout_oe);

  assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !dout_oe |-> (dout == 4'h0));

  assert_rhold_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (rclr_n && ren_n) |=> $stable(rptr));

  assert_rclr_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (!rclr_n && ren_n) |=> (rptr == '0));

  assert_wwrap_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (wclr_n && !wen_n && wptr == LAST) |=> (wptr == '0));

  assert_rwrap_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (rclr_n && !ren_n && rptr == LAST) |=> (rptr == '0));

  always @(posedge clk) begin
    if (!por_n) begin
      assert_por_quiet_R10: assert (!dout_oe && dout == 4'h0 && wptr == '0 && rptr == '0);
    end
  end
endmodule

bind ddm_chan ddm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .por_n   (por_n),
  .srst_n  (srst_n),
  .wen_n   (wen_n),
  .wclr_n  (wclr_n),
  .ren_n   (ren_n),
  .rclr_n  (rclr_n),
  .wptr    (wptr),
  .rptr    (rptr),
  .dout    (dout),
  .dout_oe (dout_oe)
);

// File: tb/dual_delay_mem_bench.sv
module dual_delay_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_PERIOD   = CLK_PERIOD + 4;
  localparam int DEPTH      = 16;

  logic       por_n;
  logic       a_clk, b_clk;
  logic [3:0] a_din, b_din;
  logic       a_wen_n, a_wclr_n, a_ren_n, a_rclr_n;
  logic       b_wen_n, b_wclr_n, b_ren_n, b_rclr_n;
  logic [3:0] a_dout, b_dout;
  logic       a_dout_oe, b_dout_oe;

  int checks;
  int fails;

  dual_delay_mem #(.DEPTH(DEPTH)) u_dual_delay_mem (
    .por_n(por_n),
    .a_clk(a_clk), .a_din(a_din), .a_wen_n(a_wen_n), .a_wclr_n(a_wclr_n),
    .a_ren_n(a_ren_n), .a_rclr_n(a_rclr_n), .a_dout(a_dout), .a_dout_oe(a_dout_oe),
    .b_clk(b_clk), .b_din(b_din), .b_wen_n(b_wen_n), .b_wclr_n(b_wclr_n),
    .b_ren_n(b_ren_n), .b_rclr_n(b_rclr_n), .b_dout(b_dout), .b_dout_oe(b_dout_oe)
  );

  initial begin
    a_clk = 1'b0;
    forever #(CLK_PERIOD / 2) a_clk = ~a_clk;
  end

  initial begin
    b_clk = 1'b0;
    forever #(B_PERIOD / 2) b_clk = ~b_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one channel A edge: inputs applied at a falling edge, outputs seen at the next falling edge
  task automatic cyc_a(input bit we, input bit wc, input bit re, input bit rc, input logic [3:0] d);
    a_wen_n = ~we; a_wclr_n = ~wc; a_ren_n = ~re; a_rclr_n = ~rc; a_din = d;
    @(negedge a_clk);
  endtask

  task automatic cyc_b(input bit we, input bit wc, input bit re, input bit rc, input logic [3:0] d);
    b_wen_n = ~we; b_wclr_n = ~wc; b_ren_n = ~re; b_rclr_n = ~rc; b_din = d;
    @(negedge b_clk);
  endtask

  task automatic expect_a(input logic [3:0] d, input string req);
    chk(a_dout_oe == 1'b1, req, a_dout_oe, 1);
    chk(a_dout == d, req, a_dout, d);
  endtask

  function automatic logic [3:0] wrap_val(input int i);
    return 4'((i * 3 + 1) & 15);
  endfunction

  function automatic logic [3:0] dly_val(input int k);
    return 4'((k * 5 + 2) & 15);
  endfunction

  task automatic t_reset;
    por_n = 1'b0;
    a_wen_n = 1'b1; a_wclr_n = 1'b1; a_ren_n = 1'b1; a_rclr_n = 1'b1; a_din = '0;
    b_wen_n = 1'b1; b_wclr_n = 1'b1; b_ren_n = 1'b1; b_rclr_n = 1'b1; b_din = '0;
    repeat (3) @(negedge a_clk);
    chk(a_dout_oe == 1'b0 && a_dout == 4'h0, "R10 reset A", {a_dout_oe, a_dout}, 0);
    chk(b_dout_oe == 1'b0 && b_dout == 4'h0, "R10 reset B", {b_dout_oe, b_dout}, 0);
    por_n = 1'b1;
    repeat (4) @(negedge b_clk);
    @(negedge a_clk);
  endtask

  task automatic t_b_load;
    @(negedge b_clk);
    cyc_b(1, 1, 0, 0, 4'hA);
    cyc_b(1, 0, 0, 0, 4'hB);
    cyc_b(0, 0, 0, 0, 4'h0);
  endtask

  task automatic t_basic;
    logic [3:0] vals [5] = '{4'h3, 4'h7, 4'hA, 4'hC, 4'hF};
    cyc_a(1, 1, 0, 0, vals[0]);
    for (int i = 1; i < 5; i++) cyc_a(1, 0, 0, 0, vals[i]);
    chk(a_dout_oe == 1'b0, "R6 no read during writes", a_dout_oe, 0);
    cyc_a(0, 0, 1, 1, 4'h0);
    expect_a(vals[0], "R5 R7 first read");
    for (int i = 1; i < 5; i++) begin
      cyc_a(0, 0, 1, 0, 4'h0);
      expect_a(vals[i], "R2 R5 sequential read");
    end
    chk(b_dout_oe == 1'b0, "R1 B quiet while A reads", b_dout_oe, 0);
    cyc_a(0, 0, 0, 0, 4'h0);
    chk(a_dout_oe == 1'b0 && a_dout == 4'h0, "R6 disabled output", {a_dout_oe, a_dout}, 0);
  endtask

  task automatic t_hold;
    cyc_a(1, 1, 0, 0, 4'h1);
    cyc_a(1, 0, 0, 0, 4'h2);
    cyc_a(0, 0, 0, 0, 4'h9);
    cyc_a(0, 0, 0, 0, 4'h9);
    cyc_a(1, 0, 0, 0, 4'h3);
    cyc_a(0, 0, 1, 1, 4'h0);
    expect_a(4'h1, "R3 hold first");
    cyc_a(0, 0, 0, 0, 4'h0);
    chk(a_dout_oe == 1'b0, "R6 read paused", a_dout_oe, 0);
    cyc_a(0, 0, 1, 0, 4'h0);
    expect_a(4'h2, "R6 read pointer held");
    cyc_a(0, 0, 1, 0, 4'h0);
    expect_a(4'h3, "R3 no write while disabled");
  endtask

  task automatic t_clear_with_enable;
    cyc_a(1, 0, 0, 0, 4'h4);
    cyc_a(1, 1, 0, 0, 4'h6);
    cyc_a(1, 0, 0, 0, 4'h8);
    cyc_a(0, 0, 1, 1, 4'h0);
    expect_a(4'h6, "R4 R7 clear plus access at zero");
    cyc_a(0, 0, 1, 0, 4'h0);
    expect_a(4'h8, "R4 pointer continues at one");
  endtask

  task automatic t_wrap;
    cyc_a(1, 1, 0, 0, wrap_val(0));
    for (int i = 1; i < DEPTH; i++) cyc_a(1, 0, 0, 0, wrap_val(i));
    cyc_a(1, 0, 0, 0, 4'hD);
    cyc_a(0, 0, 1, 1, 4'h0);
    expect_a(4'hD, "R8 write wrap overwrote address 0");
    for (int i = 1; i < DEPTH; i++) begin
      cyc_a(0, 0, 1, 0, 4'h0);
      expect_a(wrap_val(i), "R8 full sweep");
    end
    cyc_a(0, 0, 1, 0, 4'h0);
    expect_a(4'hD, "R8 read wrap to address 0");
  endtask

  task automatic t_same_addr;
    cyc_a(1, 1, 1, 1, 4'h5);
    expect_a(4'hD, "R9 read returns old word");
    cyc_a(0, 0, 1, 1, 4'h0);
    expect_a(4'h5, "R9 new word stored");
  endtask

  task automatic t_delay;
    localparam int N = 5;
    for (int k = 0; k < 20; k++) begin
      cyc_a(1, k == 0, k >= N, k == N, dly_val(k));
      if (k >= N) expect_a(dly_val(k - N), "R11 fixed delay");
    end
    cyc_a(0, 0, 0, 0, 4'h0);
  endtask

  task automatic t_b_check;
    @(negedge b_clk);
    chk(b_dout_oe == 1'b0, "R1 B output untouched", b_dout_oe, 0);
    cyc_b(0, 0, 1, 1, 4'h0);
    chk(b_dout_oe == 1'b1 && b_dout == 4'hA, "R1 B word 0 kept", b_dout, 4'hA);
    cyc_b(0, 0, 1, 0, 4'h0);
    chk(b_dout_oe == 1'b1 && b_dout == 4'hB, "R1 B word 1 kept", b_dout, 4'hB);
    cyc_b(0, 0, 0, 0, 4'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    t_reset();
    t_b_load();
    @(negedge a_clk);
    t_basic();
    t_hold();
    t_clear_with_enable();
    t_wrap();
    t_same_addr();
    t_delay();
    t_b_check();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule